// File: doc/BRIEF.md
# Self-Timed Program and Erase Sequencer

This block sits behind the serial command front-end of a small non-volatile word memory and owns everything that modifies the storage array. It keeps the write-enable latch and accepts decoded programming requests: single-word write, single-word erase, write of one pattern to every word, and erase of every word. A request waits until chip select falls and then starts a self-timed busy interval. The real high-voltage programming time is modelled by a counter of `PROG_CYCLES` system clocks. While the interval runs, the block drives word-wide write strobes into the backing array: first an erase pass that writes all ones, then a program pass for the operations that carry data.

The front-end drives a ready/busy bit on the serial data output while chip select is high and the status indication is armed. Chip select high with data input high on a rising serial clock edge disarms that indication. Programming is accepted only when the latch is set and the supply-ok flag is true at the chip-select falling edge. Any request that arrives during the busy interval is dropped.

The controller has five states. `ST_IDLE` waits for a programming request and moves to `ST_ARMED` when one is decoded. `ST_ARMED` holds the captured request; a later request replaces it. A chip-select fall moves it to `ST_CLEAR` if the start is allowed and back to `ST_IDLE` if not. `ST_CLEAR` writes ones, either to one word or across all words in ascending order. From there it goes to `ST_FILL` when the operation carries data, or to `ST_HOLD` otherwise. `ST_FILL` writes the data word, to one word or across all words, and then goes to `ST_HOLD`. `ST_HOLD` waits for the timer to expire and then returns to `ST_IDLE`. `PROG_CYCLES` must be at least 2·2^`ADDR_W`+1 so that both passes finish inside the interval.

Top module: `prog_seq_top`

## Requirements
- R1: After reset, `stat_bit` is 1, `stat_oe` is 0, `arr_we` is 0 and the write-enable latch is clear, so a programming request issued before any enable produces no array write.
- R2: Command code 1 (enable) sets the write-enable latch and code 2 (disable) clears it. Code 7 (read), and every other code, leaves the latch unchanged.
- R3: A programming request (codes 3 to 6) starts only at the clock edge where chip select is sampled low after being high, with the latch set and `supply_ok` high at that edge. Otherwise the request is discarded: no array write occurs and `stat_bit` stays 1.
- R4: `stat_bit` is 0 from the start edge for exactly `PROG_CYCLES` clock cycles and 1 afterwards. `arr_we` is only ever high while `stat_bit` is 0.
- R5: Code 3 (write) gives exactly two array writes to the given address: first all ones, then the data word.
- R6: Code 4 (erase) gives exactly one array write of all ones to the given address.
- R7: Code 5 (write-all) writes all ones to every address in ascending order, then writes the data word to every address in ascending order.
- R8: Code 6 (erase-all) writes all ones to every address in ascending order, one address per cycle.
- R9: `stat_oe` equals chip select ANDed with an internal flag. The flag is set when programming starts and is cleared by chip select high, `di` high and an `sk_rise` pulse all sampled on the same clock edge.
- R10: Requests and chip-select falls during the busy interval are ignored. Once the interval ends, no write follows from them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| cs | input | 1 | Chip select, synchronous to clk |
| di | input | 1 | Serial data input level |
| sk_rise | input | 1 | One-cycle pulse marking a serial clock rising edge |
| cmd_valid | input | 1 | Decoded command present this cycle |
| cmd_op | input | 3 | Command code (1 enable, 2 disable, 3 write, 4 erase, 5 write-all, 6 erase-all, 7 read) |
| cmd_addr | input | ADDR_W | Word address of the command |
| cmd_data | input | DATA_W | Data word of the command |
| supply_ok | input | 1 | Supply above the lock-out level |
| arr_we | output | 1 | Array word write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |
| stat_oe | output | 1 | Front-end should drive status on the data output |
| stat_bit | output | 1 | Ready (1) or busy (0) |

## Verification
Each programming code is tried with the latch clear, with the latch set but the supply low, and with both conditions met. Only the last may produce writes, which separates the two start guards from each other and from the code decode. The exact sequence of array strobes is logged and compared with the expected one. This tells a missing erase-before-write and a wrong sweep order apart from a wrong final memory image. Random sequences of enable, disable, read and programming codes with mostly-good supply check the latch history against a memory model. Directed cases cover the exact busy length, the status clear combination, a request or chip-select fall injected mid-interval, and a disable that lands between arming and the chip-select fall.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_WEN   = 3'd1,
        OP_WDS   = 3'd2,
        OP_WRITE = 3'd3,
        OP_ERASE = 3'd4,
        OP_WRALL = 3'd5,
        OP_ERAL  = 3'd6,
        OP_READ  = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_CLEAR,
        ST_FILL,
        ST_HOLD
    } seq_state_e;

    function automatic logic op_is_prog(input op_e op);
        return (op == OP_WRITE) || (op == OP_ERASE) ||
               (op == OP_WRALL) || (op == OP_ERAL);
    endfunction

    function automatic logic op_is_single(input op_e op);
        return (op == OP_WRITE) || (op == OP_ERASE);
    endfunction

    function automatic logic op_has_fill(input op_e op);
        return (op == OP_WRITE) || (op == OP_WRALL);
    endfunction

endpackage

// File: rtl/write_guard.sv
module write_guard
    import prog_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  op_e  cmd_op,
    output logic wel_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel_o <= 1'b0;
        end else if (cmd_valid) begin
            if (cmd_op == OP_WEN) begin
                wel_o <= 1'b1;
            end else if (cmd_op == OP_WDS) begin
                wel_o <= 1'b0;
            end
        end
    end

    assert_wen_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_WEN) |=> wel_o);

    assert_wds_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_WDS) |=> !wel_o);

    assert_others_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid || (cmd_op != OP_WEN && cmd_op != OP_WDS)) |=> $stable(wel_o));

endmodule

// File: rtl/busy_timer.sv
module busy_timer #(
    parameter int CYCLES = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy_o,
    output logic done_o
);

    localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_o <= 1'b1;
            cnt_q  <= LOAD;
        end else if (busy_o) begin
            if (cnt_q == '0) begin
                busy_o <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign done_o = busy_o && (cnt_q == '0);

    // R10: a new interval is never launched over a running one
    assert_start_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy_o);

endmodule

// File: rtl/rb_flag.sv
module rb_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic cs,
    input  logic di,
    input  logic sk_rise,
    output logic flag_o
);

    logic clr_hit;
    assign clr_hit = cs && di && sk_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (set_i) begin
            flag_o <= 1'b1;
        end else if (clr_hit) begin
            flag_o <= 1'b0;
        end
    end

    assert_clear_combo_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && di && sk_rise && !set_i) |=> !flag_o);

    assert_set_on_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

endmodule

// File: rtl/prog_seq_top.sv
module prog_seq_top
    import prog_seq_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              di,
    input  logic              sk_rise,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              supply_ok,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    output logic              stat_oe,
    output logic              stat_bit
);

    localparam logic [ADDR_W-1:0] LAST_IDX = {ADDR_W{1'b1}};

    op_e              op_in;
    seq_state_e       state_q, state_d;
    op_e              op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [ADDR_W-1:0] idx_q;
    logic             cs_q;
    logic             cs_fall;
    logic             wel;
    logic             start_ok;
    logic             start;
    logic             capture;
    logic             last_step;
    logic             tmr_busy;
    logic             tmr_done;
    logic             show_flag;

    assign op_in   = op_e'(cmd_op);
    assign cs_fall = cs_q && !cs;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q <= 1'b0;
        end else begin
            cs_q <= cs;
        end
    end

    write_guard u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (op_in),
        .wel_o     (wel)
    );

    busy_timer #(
        .CYCLES (PROG_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .busy_o (tmr_busy),
        .done_o (tmr_done)
    );

    rb_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (start),
        .cs      (cs),
        .di      (di),
        .sk_rise (sk_rise),
        .flag_o  (show_flag)
    );

    assign start_ok  = wel && supply_ok;
    assign start     = (state_q == ST_ARMED) && cs_fall && start_ok;
    assign last_step = op_is_single(op_q) || (idx_q == LAST_IDX);
    assign capture   = cmd_valid && op_is_prog(op_in) && !cs_fall &&
                       ((state_q == ST_IDLE) || (state_q == ST_ARMED));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (capture) begin
                    state_d = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (cs_fall) begin
                    state_d = start_ok ? ST_CLEAR : ST_IDLE;
                end
            end
            ST_CLEAR: begin
                if (last_step) begin
                    state_d = op_has_fill(op_q) ? ST_FILL : ST_HOLD;
                end
            end
            ST_FILL: begin
                if (last_step) begin
                    state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (tmr_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // request capture and sweep index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= OP_NONE;
            addr_q <= '0;
            data_q <= '0;
            idx_q  <= '0;
        end else begin
            if (capture) begin
                op_q   <= op_in;
                addr_q <= cmd_addr;
                data_q <= cmd_data;
            end
            if (start) begin
                idx_q <= '0;
            end else if ((state_q == ST_CLEAR) || (state_q == ST_FILL)) begin
                idx_q <= last_step ? '0 : idx_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        arr_we    = 1'b0;
        arr_addr  = op_is_single(op_q) ? addr_q : idx_q;
        arr_wdata = {DATA_W{1'b1}};
        unique case (state_q)
            ST_CLEAR: begin
                arr_we = 1'b1;
            end
            ST_FILL: begin
                arr_we    = 1'b1;
                arr_wdata = data_q;
            end
            default: begin
                arr_we = 1'b0;
            end
        endcase
        stat_bit = !tmr_busy;
        stat_oe  = show_flag && cs;
    end

    assert_we_only_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> !stat_bit);

    assert_sweep_fits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_done |-> (state_q == ST_HOLD));

    assert_start_guarded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLEAR && $past(state_q) == ST_ARMED) |->
            $past(wel && supply_ok && cs_fall));

    assert_fill_has_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL) |-> op_has_fill(op_q));

    assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_CLEAR || state_q == ST_FILL || state_q == ST_HOLD) && cmd_valid)
            |=> (state_q != ST_ARMED));

endmodule

// File: tb/prog_seq_top_tb.sv
module prog_seq_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 16;
    localparam int P      = 48;
    localparam int W      = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cs = 1'b0, di = 1'b0, sk_rise = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [2:0]        cmd_op = 3'd0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [DATA_W-1:0] cmd_data = '0;
    logic              supply_ok = 1'b1;
    logic              arr_we;
    logic [ADDR_W-1:0] arr_addr;
    logic [DATA_W-1:0] arr_wdata;
    logic              stat_oe, stat_bit;

    int total = 0, bad = 0;
    bit finished = 0;

    logic [ADDR_W-1:0] log_a [64];
    logic [DATA_W-1:0] log_d [64];
    int                logn = 0;
    logic [DATA_W-1:0] shadow [W];
    logic [DATA_W-1:0] model  [W];
    bit                wen_m = 0;

    prog_seq_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(P)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .di(di), .sk_rise(sk_rise),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .supply_ok(supply_ok), .arr_we(arr_we),
        .arr_addr(arr_addr), .arr_wdata(arr_wdata), .stat_oe(stat_oe),
        .stat_bit(stat_bit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (rst_n && arr_we) begin
            if (logn < 64) begin
                log_a[logn] = arr_addr;
                log_d[logn] = arr_wdata;
            end
            logn = logn + 1;
            shadow[arr_addr] = arr_wdata;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit is_prog(input int op);
        return (op >= 3) && (op <= 6);
    endfunction

    function automatic int exp_count(input int op);
        case (op)
            3: return 2;
            4: return 1;
            5: return 2 * W;
            6: return W;
            default: return 0;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] exp_addr(input int op, input logic [ADDR_W-1:0] a, input int i);
        if (op == 3 || op == 4) return a;
        return ADDR_W'(i % W);
    endfunction

    function automatic logic [DATA_W-1:0] exp_data(input int op, input logic [DATA_W-1:0] d, input int i);
        if (op == 3 && i == 1) return d;
        if (op == 5 && i >= W) return d;
        return {DATA_W{1'b1}};
    endfunction

    function automatic string tag_of(input int op);
        case (op)
            3: return "R5";
            4: return "R6";
            5: return "R7";
            6: return "R8";
            default: return "R2";
        endcase
    endfunction

    task automatic send(input int op, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        cs = 1'b1;
        cmd_valid = 1'b1;
        cmd_op = 3'(op);
        cmd_addr = a;
        cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic drop_cs();
        @(negedge clk);
        cs = 1'b0;
    endtask

    task automatic verify(input int op, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                          input bit acc, input string tag);
        int n_exp;
        int mism;
        n_exp = acc ? exp_count(op) : 0;
        chk(logn == n_exp, {tag, " write count"}, logn, n_exp);
        mism = 0;
        for (int i = 0; i < n_exp && i < 64; i++) begin
            if (log_a[i] !== exp_addr(op, a, i) || log_d[i] !== exp_data(op, d, i)) mism++;
        end
        chk(mism == 0, {tag, " write sequence"}, mism, 0);
        if (acc) begin
            if (op == 3) model[a] = d;
            else if (op == 4) model[a] = '1;
            else for (int k = 0; k < W; k++) model[k] = (op == 5) ? d : '1;
        end
        mism = 0;
        for (int k = 0; k < W; k++) if (shadow[k] !== model[k]) mism++;
        chk(mism == 0, {tag, " memory image"}, mism, 0);
    endtask

    task automatic run_op(input int op, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                          input bit sup, input string tag);
        bit acc;
        acc = is_prog(op) && wen_m && sup;
        logn = 0;
        supply_ok = sup;
        send(op, a, d);
        drop_cs();
        repeat (P + 4) @(negedge clk);
        chk(stat_bit == 1'b1, {tag, " ready after op"}, stat_bit, 1);
        verify(op, a, d, acc, tag);
        if (op == 1) wen_m = 1;
        if (op == 2) wen_m = 0;
        supply_ok = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        for (int k = 0; k < W; k++) begin
            shadow[k] = '0;
            model[k]  = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(stat_bit == 1'b1, "R1 stat_bit", stat_bit, 1);
        chk(stat_oe == 1'b0, "R1 stat_oe", stat_oe, 0);
        chk(arr_we == 1'b0, "R1 arr_we", arr_we, 0);
        // R1: write before any enable is refused
        run_op(3, 4'd2, 16'h1234, 1, "R1");
        // R3: enabled but supply low
        run_op(1, 0, 0, 1, "R2");
        run_op(3, 4'd2, 16'h1234, 0, "R3");
        run_op(6, 4'd0, 16'h0, 0, "R3");

        // R4/R9/R5: busy length, status output and clear combination
        logn = 0;
        send(3, 4'd5, 16'hA5C3);
        drop_cs();
        @(negedge clk);
        chk(stat_bit == 1'b0, "R4 busy at start", stat_bit, 0);
        cs = 1'b1;
        @(negedge clk);
        chk(stat_oe == 1'b1, "R9 oe while busy", stat_oe, 1);
        chk(stat_bit == 1'b0, "R4 busy shown", stat_bit, 0);
        repeat (P - 2) @(negedge clk);
        chk(stat_bit == 1'b0, "R4 still busy last cycle", stat_bit, 0);
        @(negedge clk);
        chk(stat_bit == 1'b1, "R4 ready after interval", stat_bit, 1);
        chk(stat_oe == 1'b1, "R9 oe shows ready", stat_oe, 1);
        di = 1'b1;
        sk_rise = 1'b1;
        @(negedge clk);
        sk_rise = 1'b0;
        di = 1'b0;
        chk(stat_oe == 1'b0, "R9 clear combination", stat_oe, 0);
        verify(3, 4'd5, 16'hA5C3, 1, "R5");

        // R10: request during busy
        logn = 0;
        send(6, 0, 0);
        drop_cs();
        repeat (3) @(negedge clk);
        send(3, 4'd9, 16'h0F0F);
        drop_cs();
        repeat (P + 4) @(negedge clk);
        verify(6, 0, 0, 1, "R10");

        // R3: disable lands between arming and the chip-select fall
        logn = 0;
        send(4, 4'd3, 0);
        send(2, 0, 0);
        drop_cs();
        repeat (P + 4) @(negedge clk);
        wen_m = 0;
        verify(4, 4'd3, 0, 0, "R3");

        // R2: disable blocks, read keeps latch
        run_op(5, 0, 16'h5555, 1, "R2");
        run_op(1, 0, 0, 1, "R2");
        run_op(7, 0, 0, 1, "R2");
        run_op(5, 0, 16'h3C3C, 1, "R7");
        run_op(4, 4'd7, 0, 1, "R6");
        run_op(3, 4'd7, 16'h0001, 1, "R5");
        run_op(6, 0, 0, 1, "R8");

        for (int n = 0; n < 40; n++) begin
            int op;
            bit sup;
            op  = int'($urandom_range(1, 7));
            sup = ($urandom_range(0, 5) != 0);
            run_op(op, ADDR_W'($urandom), DATA_W'($urandom), sup, tag_of(op));
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule